// File: doc/BRIEF.md
# Burst-Tracking Memory Cycle Controller

This block sits between a processor data bus and a burst-capable memory array. Each bus cycle is either an access or an internal (idle) cycle. An access is marked as opening a new transfer or as continuing a burst. The controller follows each burst and predicts the address of the next beat. When the memory needs extra time, it drops a clock-enable output to stall the processor.

An access that opens a burst pays a fixed row-open penalty of `WAIT_OPEN` stall cycles. Beats that continue a healthy burst stream with no stall. Any beat that breaks the burst rules sets a sticky protocol error, and the controller serves that beat as a fresh opening access. A small behavioural word array, built into the block, answers the accesses.

Back-pressure works as follows. `bus_req` plays the part of valid and `clk_en` plays the part of ready. An access is accepted and completes on the rising edge where both are high. While `clk_en` is low, the processor must hold every bus input steady. The controller's tracking state does not move during that time. An idle cycle is never stalled.

Top module: `burst_mem_ctrl`

## Requirements
- R1: After the active-low synchronous reset, `clk_en` is high, `proto_err` is low and no burst is open.
- R2: An access with `bus_seq`=0 holds `clk_en` low for exactly `WAIT_OPEN` (default 3) cycles. `clk_en` then rises in the cycle where the access completes.
- R3: A continuation beat (`bus_seq`=1) is served with `clk_en` held high and no error, when three conditions hold: a word burst is open, the beat's address equals the previous beat's address plus 4, and it keeps the burst's settings.
- R4: A continuation beat at an address other than the predicted one sets `proto_err`. It is served with the `WAIT_OPEN` stall, and a new burst starts from its address.
- R5: A continuation beat that directly follows an idle cycle is accepted as the first beat of a burst, with no address check and no error. It pays the `WAIT_OPEN` stall, and later beats at +4 stream.
- R6: `bus_size` encodes 2'b00 byte, 2'b01 halfword and 2'b10 word. A non-word access never opens a burst, so a continuation beat after it sets `proto_err`.
- R7: A continuation beat whose `bus_write` differs from the burst's direction sets `proto_err`.
- R8: A continuation beat whose `bus_attr` differs from the burst's attributes sets `proto_err`.
- R9: Read data on `bus_rdata` is valid in the completing cycle of a read. Write data is stored at the edge that ends the completing cycle of a write.
- R10: An idle cycle (`bus_req`=0) keeps `clk_en` high and touches no memory.
- R11: `proto_err` is sticky and clears only on reset. It changes only at edges where `clk_en` is high.
- R12: While `clk_en` is low, the burst state and the predicted address are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request (valid) |
| bus_seq | input | 1 | 1 = burst continuation beat, 0 = opening access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Transfer size: 00 byte, 01 halfword, 10 word |
| bus_attr | input | 4 | Other address-class attributes, constant within a burst |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the completing cycle |
| clk_en | output | 1 | Processor clock enable (ready); low stalls the bus |
| proto_err | output | 1 | Sticky burst protocol error |

## Verification
Directed sequences drive several kinds of traffic through the block. Write bursts and then read bursts over the same words tell a correct stall count and correct stored data apart from a stream that stalls or misplaces beats. An idle-then-continue sequence separates the legal first beat after an idle cycle from a bad continuation. Broken bursts check that each rule is enforced on its own and that the error stays set: a wrong address, a reversed direction, changed attributes, or a beat after a halfword access.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10
  } xfer_size_e;

  typedef enum logic [1:0] {
    K_IDLE,
    K_OPEN,
    K_STREAM,
    K_FAULT
  } cyc_kind_e;
endpackage

// File: rtl/bmc_tracker.sv
module bmc_tracker
  import bmc_pkg::*;
#(
  parameter int AW = 32,
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic          req,
  input  logic          seq,
  input  logic          write,
  input  logic [1:0]    size,
  input  logic [TW-1:0] attr,
  input  logic [AW-1:0] addr,
  output cyc_kind_e     kind,
  output logic          need_wait,
  output logic          err
);
  localparam logic [AW-1:0] STEP = AW'(4);

  logic          open_q, idle_q, wr_q, err_q;
  logic [TW-1:0] attr_q;
  logic [AW-1:0] pred_q;
  logic          is_word, same_ctl;

  assign is_word  = (size == SZ_WORD);
  assign same_ctl = (write == wr_q) && (attr == attr_q);

  always_comb begin
    if (!req)
      kind = K_IDLE;
    else if (!seq)
      kind = K_OPEN;
    else if (idle_q && is_word)
      kind = K_OPEN;
    else if (open_q && is_word && same_ctl && addr == pred_q)
      kind = K_STREAM;
    else
      kind = K_FAULT;
  end

  assign need_wait = (kind == K_OPEN) || (kind == K_FAULT);
  assign err       = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      idle_q <= 1'b0;
      wr_q   <= 1'b0;
      attr_q <= '0;
      pred_q <= '0;
      err_q  <= 1'b0;
    end else if (ce) begin
      if (kind == K_IDLE) begin
        idle_q <= 1'b1;
        open_q <= 1'b0;
      end else begin
        idle_q <= 1'b0;
        open_q <= is_word;
        pred_q <= addr + STEP;
        wr_q   <= write;
        attr_q <= attr;
        if (kind == K_FAULT) err_q <= 1'b1;
      end
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q); // R11
  AST_ERR_ON_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(err_q)); // R11
  AST_HOLD_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(pred_q) && $stable(open_q))); // R12
  AST_FAULT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && kind == K_FAULT) |=> err_q); // R4
endmodule

// File: rtl/bmc_waitgen.sv
module bmc_waitgen #(
  parameter int WAIT_OPEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic need_wait,
  output logic ce
);
  localparam int CW = (WAIT_OPEN > 1) ? $clog2(WAIT_OPEN) : 1;
  localparam logic [CW-1:0] LOAD = (WAIT_OPEN > 0) ? CW'(WAIT_OPEN - 1) : '0;
  localparam bit HAS_WAIT = (WAIT_OPEN > 0);

  logic          held_q;
  logic [CW-1:0] cnt_q;

  always_comb begin
    if (held_q)
      ce = (cnt_q == '0);
    else
      ce = !(need_wait && HAS_WAIT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      cnt_q  <= '0;
    end else if (held_q) begin
      if (cnt_q == '0) held_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end else if (need_wait && HAS_WAIT) begin
      held_q <= 1'b1;
      cnt_q  <= LOAD;
    end
  end

  AST_HELD_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && cnt_q == '0) |=> !held_q); // R2
endmodule

// File: rtl/bmc_mem.sv
module bmc_mem #(
  parameter int DEPTH = 64,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem_q [DEPTH];
  logic [IW-1:0] idx;

  assign idx   = addr[IW+1:2];
  assign rdata = mem_q[idx];

  always_ff @(posedge clk) begin
    if (we) mem_q[idx] <= wdata;
  end
endmodule

// File: rtl/burst_mem_ctrl.sv
module burst_mem_ctrl
  import bmc_pkg::*;
#(
  parameter int WAIT_OPEN = 3,
  parameter int DEPTH     = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_req,
  input  logic        bus_seq,
  input  logic        bus_write,
  input  logic [1:0]  bus_size,
  input  logic [3:0]  bus_attr,
  input  logic [31:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        clk_en,
  output logic        proto_err
);
  localparam int RW = $clog2(WAIT_OPEN + 2) + 1;

  cyc_kind_e kind;
  logic      need_wait, mem_we;

  bmc_tracker #(.AW(32), .TW(4)) u_track (
    .clk(clk), .rst_n(rst_n), .ce(clk_en), .req(bus_req), .seq(bus_seq),
    .write(bus_write), .size(bus_size), .attr(bus_attr), .addr(bus_addr),
    .kind(kind), .need_wait(need_wait), .err(proto_err)
  );

  bmc_waitgen #(.WAIT_OPEN(WAIT_OPEN)) u_wait (
    .clk(clk), .rst_n(rst_n), .need_wait(need_wait), .ce(clk_en)
  );

  assign mem_we = clk_en && bus_req && bus_write;

  bmc_mem #(.DEPTH(DEPTH), .AW(32), .DW(32)) u_mem (
    .clk(clk), .we(mem_we), .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata)
  );

  logic          prev_ce_q;
  logic [RW-1:0] low_run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_ce_q <= 1'b1;
      low_run_q <= '0;
    end else begin
      prev_ce_q <= clk_en;
      low_run_q <= clk_en ? '0 : low_run_q + 1'b1;
    end
  end

  AST_OPEN_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    ((WAIT_OPEN != 0) && bus_req && !bus_seq && prev_ce_q) |-> !clk_en); // R2
  AST_STALL_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (!prev_ce_q && clk_en) |-> (low_run_q == RW'(WAIT_OPEN))); // R2
  AST_STALL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    low_run_q <= RW'(WAIT_OPEN)); // R2
  AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_req && prev_ce_q) |-> clk_en); // R10
endmodule

// File: tb/burst_mem_ctrl_bench.sv
module burst_mem_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_seq = 1'b0, bus_write = 1'b0;
  logic [1:0]  bus_size = 2'b10;
  logic [3:0]  bus_attr = 4'h0;
  logic [31:0] bus_addr = '0, bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        clk_en, proto_err;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  burst_mem_ctrl u_burst_mem_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_seq(bus_seq),
    .bus_write(bus_write), .bus_size(bus_size), .bus_attr(bus_attr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .clk_en(clk_en), .proto_err(proto_err)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_req = 1'b0; bus_seq = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic access(input logic rq, input logic sq, input logic wr, input logic [31:0] a,
                        input logic [1:0] sz, input logic [3:0] at, input logic [31:0] wd,
                        output int stalls, output logic [31:0] rd);
    bus_req = rq; bus_seq = sq; bus_write = wr; bus_addr = a;
    bus_size = sz; bus_attr = at; bus_wdata = wd;
    stalls = 0; rd = '0;
    forever begin
      #5;
      if (clk_en) begin
        rd = bus_rdata;
        @(posedge clk); @(negedge clk);
        break;
      end
      stalls++;
      @(posedge clk); @(negedge clk);
      if (stalls > 20) break;
    end
    bus_req = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    #5;
    check(clk_en == 1'b1, "R1 clk_en after reset", 32'(clk_en), 1);
    check(proto_err == 1'b0, "R1 proto_err after reset", 32'(proto_err), 0);
  endtask

  task automatic t_idle();
    int s; logic [31:0] r;
    access(0, 0, 1, 32'h10, 2'b10, 4'h0, 32'hDEAD, s, r);
    check(s == 0, "R10 idle cycle stalls", 32'(s), 0);
  endtask

  task automatic t_write_burst();
    int s; logic [31:0] r;
    access(1, 0, 1, 32'h10, 2'b10, 4'h3, 32'hA0A0_0001, s, r);
    check(s == 3, "R2 opening write stall", 32'(s), 3);
    access(1, 1, 1, 32'h14, 2'b10, 4'h3, 32'hB0B0_0002, s, r);
    check(s == 0, "R3 stream beat 1 stall", 32'(s), 0);
    access(1, 1, 1, 32'h18, 2'b10, 4'h3, 32'hC0C0_0003, s, r);
    check(s == 0, "R3 stream beat 2 stall", 32'(s), 0);
    #5 check(proto_err == 0, "R3 no error on clean burst", 32'(proto_err), 0);
  endtask

  task automatic t_read_burst();
    int s; logic [31:0] r;
    access(0, 0, 0, 32'h10, 2'b10, 4'h3, 32'h0, s, r);
    access(1, 0, 0, 32'h10, 2'b10, 4'h3, 32'h0, s, r);
    check(s == 3, "R2 opening read stall", 32'(s), 3);
    check(r == 32'hA0A0_0001, "R9 read beat 0", r, 32'hA0A0_0001);
    access(1, 1, 0, 32'h14, 2'b10, 4'h3, 32'h0, s, r);
    check(s == 0, "R3 read stream stall", 32'(s), 0);
    check(r == 32'hB0B0_0002, "R9 read beat 1", r, 32'hB0B0_0002);
    access(1, 1, 0, 32'h18, 2'b10, 4'h3, 32'h0, s, r);
    check(r == 32'hC0C0_0003, "R9 read beat 2", r, 32'hC0C0_0003);
    // R10: idle cycle with write data present must not alter memory
    access(0, 0, 1, 32'h14, 2'b10, 4'h3, 32'hFFFF_FFFF, s, r);
    access(1, 0, 0, 32'h14, 2'b10, 4'h3, 32'h0, s, r);
    check(r == 32'hB0B0_0002, "R10 idle left memory intact", r, 32'hB0B0_0002);
  endtask

  task automatic t_idle_then_seq();
    int s; logic [31:0] r;
    access(0, 0, 1, 32'h20, 2'b10, 4'h1, 32'h0, s, r);
    access(1, 1, 1, 32'h20, 2'b10, 4'h1, 32'h1111_2222, s, r);
    check(s == 3, "R5 first beat after idle stall", 32'(s), 3);
    access(1, 1, 1, 32'h24, 2'b10, 4'h1, 32'h3333_4444, s, r);
    check(s == 0, "R5 following beat streams", 32'(s), 0);
    #5 check(proto_err == 0, "R5 no error", 32'(proto_err), 0);
  endtask

  task automatic t_halfword();
    int s; logic [31:0] r;
    do_reset();
    access(1, 0, 0, 32'h30, 2'b01, 4'h0, 32'h0, s, r);
    check(s == 3, "R6 halfword access stall", 32'(s), 3);
    access(1, 1, 0, 32'h34, 2'b10, 4'h0, 32'h0, s, r);
    check(s == 3, "R6 beat after halfword served as opening", 32'(s), 3);
    #5 check(proto_err == 1, "R6 beat after halfword flags error", 32'(proto_err), 1);
  endtask

  task automatic t_dir_change();
    int s; logic [31:0] r;
    do_reset();
    access(1, 0, 1, 32'h40, 2'b10, 4'h0, 32'h5, s, r);
    access(1, 1, 0, 32'h44, 2'b10, 4'h0, 32'h0, s, r);
    #5 check(proto_err == 1, "R7 direction change flags error", 32'(proto_err), 1);
  endtask

  task automatic t_attr_change();
    int s; logic [31:0] r;
    do_reset();
    access(1, 0, 0, 32'h40, 2'b10, 4'h2, 32'h0, s, r);
    access(1, 1, 0, 32'h44, 2'b10, 4'h2, 32'h0, s, r);
    #5 check(proto_err == 0, "R8 matching attributes no error", 32'(proto_err), 0);
    access(1, 1, 0, 32'h48, 2'b10, 4'h6, 32'h0, s, r);
    #5 check(proto_err == 1, "R8 attribute change flags error", 32'(proto_err), 1);
  endtask

  task automatic t_addr_mismatch();
    int s; logic [31:0] r;
    do_reset();
    access(1, 0, 0, 32'h10, 2'b10, 4'h0, 32'h0, s, r);
    access(1, 1, 0, 32'h1C, 2'b10, 4'h0, 32'h0, s, r);
    check(s == 3, "R4 mismatched beat served as opening", 32'(s), 3);
    #5 check(proto_err == 1, "R4 mismatch flags error", 32'(proto_err), 1);
    access(1, 1, 0, 32'h20, 2'b10, 4'h0, 32'h0, s, r);
    check(s == 0, "R4 burst restarts at mismatched address", 32'(s), 0);
    access(0, 0, 0, 32'h0, 2'b10, 4'h0, 32'h0, s, r);
    access(0, 0, 0, 32'h0, 2'b10, 4'h0, 32'h0, s, r);
    #5 check(proto_err == 1, "R11 error stays set", 32'(proto_err), 1);
    do_reset();
    #5 check(proto_err == 0, "R11 reset clears error", 32'(proto_err), 0);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_write_burst();
    t_read_burst();
    t_idle_then_seq();
    t_halfword();
    t_dir_change();
    t_attr_change();
    t_addr_mismatch();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule